// File: doc/BRIEF.md
# Bus Interrupt Requester and Acknowledger

This block raises interrupts on the seven active-low bus request lines from two independent sources. Software can set per-level drive bits, and each one pulls its own line. A group of local event inputs share one request on a level that software programs. When the bus runs an interrupt-acknowledge cycle for a level the block is driving, the block picks the source that owns that level. It then answers with a status/ID word and raises a one-cycle acknowledged indication. On acknowledge, a software drive bit clears itself. A local request clears its latched event status bits.

For a drive bit, the status/ID word comes from a stored 16-bit register. For a local request, the word is the latched event status byte above the module's logical address. Each source can separately accept or ignore 8-bit acknowledge cycles. When it accepts them, it chooses whether the returned byte is the logical address or a stored byte. Two resets are provided. A hard reset clears everything. A soft reset withdraws all pending requests but keeps the configuration.

Top module: `irqRequester`

## Requirements
- R1: Writing the control register (address 0) with bit k set, for k in 1..7, pulls irqN[k] low after the write's clock edge. Writing the bit with 0 releases the line, unless another source holds it.
- R2: A 16-bit acknowledge (ack8=0) on a level held only by its drive bit gives ackDone=1 with ackData equal to the stored ID register (address 2) in the cycle after ackStb. The drive bit clears in that same edge, which releases the line.
- R3: Control bits 15:13 select the local request level, and the value 0 disables the local request. Control bit 8+i enables event input i. An event that is not enabled never sets its status bit.
- R4: A 16-bit acknowledge of the local request returns the event status byte in ackData[15:8], with event i at bit 8+i, and the logical address in ackData[7:0].
- R5: An event status bit sets on the clock edge where an enabled condIn[i] is first seen high. It drives the local level while set. It clears on the edge that answers a local acknowledge, and a level that stays high afterwards does not set it again.
- R6: The status register (address 1) shows the line states active-high in bits 7:1 and the event status byte in bits 15:8.
- R7: An 8-bit acknowledge (ack8=1) is answered with ackData[15:8]=0. Address 3 sets the 8-bit options: bit 0 lets drive-bit sources answer, and bit 1 selects their low byte (1 = ID register bits 7:0, 0 = logical address). Bit 2 lets the local source answer, and bit 3 selects its low byte (1 = address 3 bits 15:8, 0 = logical address). A source whose enable bit is 0 ignores 8-bit cycles and stays pending.
- R8: The hard reset clears all registers and releases all lines. softRst clears the drive bits and the event status bits and releases all lines. It keeps the level, the enables, the ID register and the 8-bit options.
- R9: When a drive bit and the local request share a level, the line stays low until both are released. Each acknowledge at that level serves the local source first.
- R10: An acknowledge of level 0, or of a level with no source able to answer, gives no ackDone and changes no state.
- R11: If a control write and an acknowledge of a drive bit fall in the same edge, the acknowledged bit ends cleared and the other bits take the written value. If a new event edge and a local acknowledge fall in the same edge, the new status bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Hard reset, active low, asynchronous |
| softRst | input | 1 | Soft reset, synchronous, active high |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 control, 1 status, 2 ID, 3 8-bit options) |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data for regAddr |
| condIn | input | NUM_COND | Local event inputs |
| logicalAddr | input | 8 | Module logical address |
| ackStb | input | 1 | Acknowledge cycle present, one clock |
| ackLevel | input | 3 | Level being acknowledged |
| ack8 | input | 1 | 1 = 8-bit status/ID cycle, 0 = 16-bit |
| ackDone | output | 1 | Acknowledge answered, one clock |
| ackData | output | 16 | Status/ID word returned |
| irqN | output | 7 | Request lines, index 7:1, active low |

## Verification
Software writes to the control register and the bus acknowledge that clears a drive bit can land on the same clock edge, because both update the same drive register. The bench provokes this by presenting the write and the acknowledge in one cycle. It then judges the result by reading back the control register: the acknowledged bit must be 0 and the newly written bit must be 1. A second collision pairs a fresh event edge with a local acknowledge in one cycle. The bench expects the status byte to stay set and the line to stay low until a further acknowledge.

// File: rtl/irqReqPkg.sv
package irqReqPkg;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 2 * BYTE_W;
  localparam int NUM_LVL = 7;
  localparam int LVL_W   = 3;
  localparam int EN_W    = 5;
  localparam int ADDR_W  = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_ID   = 2'd2;
  localparam logic [ADDR_W-1:0] A_OPT  = 2'd3;

  localparam int F_LVL_LO = 13;
  localparam int F_EN_LO  = 8;

  typedef struct packed {
    logic wrCtrl;
    logic wrId;
    logic wrOpt;
    logic ackLoc;
    logic ackSw;
    logic softClr;
  } strobeT;
endpackage

// File: rtl/irqCtrl.sv
module irqCtrl
  import irqReqPkg::*;
(
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              softRst,
  input  logic              ackStb,
  input  logic [LVL_W-1:0]  ackLevel,
  input  logic              ack8,
  input  logic [NUM_LVL:1]  driveVec,
  input  logic [LVL_W-1:0]  locLevel,
  input  logic              locPending,
  input  logic              swSid8,
  input  logic              locSid8,
  output strobeT            st
);
  logic [NUM_LVL:0] driveFull;
  logic levelOk, locHere, locCan, swHere, swCan;

  always_comb begin
    driveFull = {driveVec, 1'b0};
    levelOk   = (ackLevel != '0);
    locHere   = levelOk && locPending && (locLevel == ackLevel);
    locCan    = locHere && (!ack8 || locSid8);
    swHere    = levelOk && driveFull[ackLevel];
    swCan     = swHere && (!ack8 || swSid8);

    st.softClr = softRst;
    st.wrCtrl  = regWe && !softRst && (regAddr == A_CTRL);
    st.wrId    = regWe && !softRst && (regAddr == A_ID);
    st.wrOpt   = regWe && !softRst && (regAddr == A_OPT);
    st.ackLoc  = ackStb && !softRst && locCan;
    st.ackSw   = ackStb && !softRst && !locCan && swCan;
  end
endmodule

// File: rtl/irqDatapath.sv
module irqDatapath
  import irqReqPkg::*;
#(
  parameter int NUM_COND = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobeT              st,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [WORD_W-1:0]   regWdata,
  output logic [WORD_W-1:0]   regRdata,
  input  logic [NUM_COND-1:0] condIn,
  input  logic [BYTE_W-1:0]   logicalAddr,
  input  logic [LVL_W-1:0]    ackLevel,
  input  logic                ack8,
  output logic                ackDone,
  output logic [WORD_W-1:0]   ackData,
  output logic [NUM_LVL:1]    irqN,
  output logic [NUM_LVL:1]    driveVec,
  output logic [LVL_W-1:0]    locLevel,
  output logic                locPending,
  output logic                swSid8,
  output logic                locSid8
);
  localparam int LV_N = NUM_LVL + 1;

  logic [NUM_LVL:1]    drive;
  logic [LVL_W-1:0]    level;
  logic [EN_W-1:0]     condEn;
  logic [WORD_W-1:0]   idReg;
  logic [WORD_W-1:0]   optReg;
  logic [NUM_COND-1:0] condStat, condPrev, condRise;
  logic [NUM_LVL:1]    lineAct;
  logic [LV_N-1:0]     clrFull;
  logic [BYTE_W-1:0]   statByte, locLow, swLow;
  logic [WORD_W-1:0]   reply;
  logic [EN_W-1:0]     enRead;

  assign swSid8  = optReg[0];
  assign locSid8 = optReg[2];
  assign locLow  = optReg[3] ? optReg[WORD_W-1:BYTE_W] : logicalAddr;
  assign swLow   = optReg[1] ? idReg[BYTE_W-1:0] : logicalAddr;

  assign driveVec   = drive;
  assign locLevel   = level;
  assign locPending = (|condStat) && (level != '0);
  assign condRise   = condIn & ~condPrev & condEn[NUM_COND-1:0];
  assign statByte   = {{(BYTE_W-NUM_COND){1'b0}}, condStat};
  assign clrFull    = st.ackSw ? (LV_N'(1) << ackLevel) : '0;
  assign enRead     = condEn;

  for (genvar k = 1; k <= NUM_LVL; k++) begin : gLine
    assign lineAct[k] = drive[k] | (locPending && (level == LVL_W'(k)));
    assign irqN[k]    = ~lineAct[k];
  end

  always_comb begin
    reply = '0;
    if (st.ackLoc)
      reply = ack8 ? {{BYTE_W{1'b0}}, locLow} : {statByte, logicalAddr};
    else if (st.ackSw)
      reply = ack8 ? {{BYTE_W{1'b0}}, swLow} : idReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      drive  <= '0;
      level  <= '0;
      condEn <= '0;
      idReg  <= '0;
      optReg <= '0;
    end else if (st.softClr) begin
      drive <= '0;
    end else begin
      if (st.wrCtrl) begin
        drive  <= regWdata[NUM_LVL:1] & ~clrFull[NUM_LVL:1];
        level  <= regWdata[F_LVL_LO +: LVL_W];
        condEn <= regWdata[F_EN_LO +: EN_W];
      end else begin
        drive <= drive & ~clrFull[NUM_LVL:1];
      end
      if (st.wrId)  idReg  <= regWdata;
      if (st.wrOpt) optReg <= regWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      condStat <= '0;
      condPrev <= '0;
    end else begin
      condPrev <= condIn;
      if (st.softClr)     condStat <= '0;
      else if (st.ackLoc) condStat <= condRise;
      else                condStat <= condStat | condRise;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackDone <= 1'b0;
      ackData <= '0;
    end else begin
      ackDone <= st.ackLoc | st.ackSw;
      if (st.ackLoc | st.ackSw) ackData <= reply;
    end
  end

  always_comb begin
    unique case (regAddr)
      A_CTRL:  regRdata = {level, enRead, drive, 1'b0};
      A_STAT:  regRdata = {statByte, lineAct, 1'b0};
      A_ID:    regRdata = idReg;
      default: regRdata = optReg;
    endcase
  end
endmodule

// File: rtl/irqRequester.sv
module irqRequester
  import irqReqPkg::*;
#(
  parameter int NUM_COND = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                softRst,
  input  logic                regWe,
  input  logic [1:0]          regAddr,
  input  logic [15:0]         regWdata,
  output logic [15:0]         regRdata,
  input  logic [NUM_COND-1:0] condIn,
  input  logic [7:0]          logicalAddr,
  input  logic                ackStb,
  input  logic [2:0]          ackLevel,
  input  logic                ack8,
  output logic                ackDone,
  output logic [15:0]         ackData,
  output logic [7:1]          irqN
);
  strobeT             st;
  logic [NUM_LVL:1]   driveVec;
  logic [LVL_W-1:0]   locLevel;
  logic               locPending, swSid8, locSid8;

  irqCtrl uCtrl (
    .regWe(regWe), .regAddr(regAddr), .softRst(softRst),
    .ackStb(ackStb), .ackLevel(ackLevel), .ack8(ack8),
    .driveVec(driveVec), .locLevel(locLevel), .locPending(locPending),
    .swSid8(swSid8), .locSid8(locSid8), .st(st)
  );

  irqDatapath #(.NUM_COND(NUM_COND)) uPath (
    .clk(clk), .rstN(rstN), .st(st), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .condIn(condIn),
    .logicalAddr(logicalAddr), .ackLevel(ackLevel), .ack8(ack8),
    .ackDone(ackDone), .ackData(ackData), .irqN(irqN),
    .driveVec(driveVec), .locLevel(locLevel), .locPending(locPending),
    .swSid8(swSid8), .locSid8(locSid8)
  );
endmodule

// File: rtl/irqRequesterChk.sv
module irqRequesterChk (
  input logic        clk,
  input logic        rstN,
  input logic        softRst,
  input logic [1:0]  regAddr,
  input logic [15:0] regRdata,
  input logic        ackStb,
  input logic [2:0]  ackLevel,
  input logic        ack8,
  input logic        ackDone,
  input logic [15:0] ackData,
  input logic [7:1]  irqN
);
  logic [7:0] lineHi;
  assign lineHi = {~irqN, 1'b0};

  // R10
  ack_needs_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackDone |-> $past(ackStb));

  // R10
  ack_on_driven_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackDone |-> $past(lineHi[ackLevel]));

  // R7
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackDone && $past(ack8)) |-> (ackData[15:8] == 8'h00));

  // R8
  soft_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(softRst) |-> (irqN == 7'h7F && !ackDone));

  // R6
  line_readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd1) |-> (regRdata[7:1] == ~irqN));
endmodule

bind irqRequester irqRequesterChk uChk (
  .clk(clk), .rstN(rstN), .softRst(softRst), .regAddr(regAddr),
  .regRdata(regRdata), .ackStb(ackStb), .ackLevel(ackLevel), .ack8(ack8),
  .ackDone(ackDone), .ackData(ackData), .irqN(irqN)
);

// File: tb/sim_irqRequester.sv
`timescale 1ns/1ps
module sim_irqRequester;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        softRst = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic [1:0]  condIn = '0;
  logic [7:0]  logicalAddr = 8'h3C;
  logic        ackStb = 1'b0;
  logic [2:0]  ackLevel = '0;
  logic        ack8 = 1'b0;
  logic        ackDone;
  logic [15:0] ackData;
  logic [7:1]  irqN;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  irqRequester #(.NUM_COND(2)) u0 (.*);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rdChk(string req, logic [1:0] a, logic [15:0] exp);
    regAddr = a;
    #1;
    chk(req, regRdata, exp);
  endtask

  task automatic doAck(logic [2:0] lvl, logic w8, output logic done, output logic [15:0] data);
    @(negedge clk);
    ackStb = 1'b1; ackLevel = lvl; ack8 = w8;
    @(negedge clk);
    ackStb = 1'b0; ackLevel = '0; ack8 = 1'b0;
    done = ackDone; data = ackData;
  endtask

  task automatic edge0();
    @(negedge clk); condIn[0] = 1'b0;
    @(negedge clk); condIn[0] = 1'b1;
    @(negedge clk);
  endtask

  task automatic tReset();
    chk("R8 reset lines", {9'd0, irqN}, 16'h007F);
    chk("R8 reset ackDone", {15'd0, ackDone}, 16'h0000);
    for (int a = 0; a < 4; a++) rdChk("R8 reset regs", 2'(a), 16'h0000);
  endtask

  task automatic tDrive();
    wr(2'd0, 16'h00A4);
    chk("R1 drive lines", {9'd0, irqN}, {9'd0, 7'b0101101});
    rdChk("R6 line readback", 2'd1, 16'h00A4);
  endtask

  task automatic tSwAck();
    logic d; logic [15:0] v;
    wr(2'd2, 16'hBEEF);
    doAck(3'd5, 1'b0, d, v);
    chk("R2 ackDone", {15'd0, d}, 16'h0001);
    chk("R2 ackData", v, 16'hBEEF);
    chk("R2 line5 released", {9'd0, irqN}, {9'd0, 7'b0111101});
  endtask

  task automatic tNoResp();
    logic d; logic [15:0] v;
    doAck(3'd5, 1'b0, d, v);
    chk("R10 undriven level", {15'd0, d}, 16'h0000);
    doAck(3'd0, 1'b0, d, v);
    chk("R10 level zero", {15'd0, d}, 16'h0000);
    chk("R10 lines kept", {9'd0, irqN}, {9'd0, 7'b0111101});
  endtask

  task automatic tNarrowSw();
    logic d; logic [15:0] v;
    doAck(3'd7, 1'b1, d, v);
    chk("R7 8-bit ignored", {15'd0, d}, 16'h0000);
    chk("R7 line7 kept", {9'd0, irqN}, {9'd0, 7'b0111101});
    wr(2'd3, 16'h5A01);
    doAck(3'd7, 1'b1, d, v);
    chk("R7 8-bit LA done", {15'd0, d}, 16'h0001);
    chk("R7 8-bit LA data", v, 16'h003C);
    wr(2'd3, 16'h5A03);
    doAck(3'd2, 1'b1, d, v);
    chk("R7 8-bit stored data", v, 16'h00EF);
    chk("R7 all released", {9'd0, irqN}, 16'h007F);
  endtask

  task automatic tLocal();
    logic d; logic [15:0] v;
    wr(2'd0, 16'h8100);
    @(negedge clk); condIn[0] = 1'b1;
    @(negedge clk);
    rdChk("R5 status set", 2'd1, 16'h0110);
    chk("R3 level4 line", {9'd0, irqN}, {9'd0, 7'b1110111});
    doAck(3'd4, 1'b0, d, v);
    chk("R4 local data", v, 16'h013C);
    chk("R5 released", {9'd0, irqN}, 16'h007F);
    rdChk("R5 status cleared held input", 2'd1, 16'h0000);
    @(negedge clk); condIn[1] = 1'b1;
    @(negedge clk); @(negedge clk);
    rdChk("R3 disabled event", 2'd1, 16'h0000);
    condIn[1] = 1'b0;
    edge0();
    doAck(3'd4, 1'b1, d, v);
    chk("R7 local 8-bit ignored", {15'd0, d}, 16'h0000);
    rdChk("R7 local still pending", 2'd1, 16'h0110);
    wr(2'd3, 16'h5A0F);
    doAck(3'd4, 1'b1, d, v);
    chk("R7 local 8-bit stored", v, 16'h005A);
    chk("R7 local released", {9'd0, irqN}, 16'h007F);
  endtask

  task automatic tShared();
    logic d; logic [15:0] v;
    wr(2'd0, 16'h8110);
    edge0();
    doAck(3'd4, 1'b0, d, v);
    chk("R9 local first", v, 16'h013C);
    chk("R9 line still low", {9'd0, irqN}, {9'd0, 7'b1110111});
    doAck(3'd4, 1'b0, d, v);
    chk("R9 sw second", v, 16'hBEEF);
    chk("R9 line released", {9'd0, irqN}, 16'h007F);
  endtask

  task automatic tCollide();
    logic d; logic [15:0] v;
    wr(2'd0, 16'h8010);
    @(negedge clk);
    regWe = 1'b1; regAddr = 2'd0; regWdata = 16'h8018;
    ackStb = 1'b1; ackLevel = 3'd4; ack8 = 1'b0;
    @(negedge clk);
    regWe = 1'b0; ackStb = 1'b0; ackLevel = '0;
    chk("R11 ack answered", ackData, 16'hBEEF);
    rdChk("R11 write vs clear", 2'd0, 16'h8008);
    wr(2'd0, 16'h8100);
    edge0();
    @(negedge clk); condIn[0] = 1'b0;
    @(negedge clk);
    condIn[0] = 1'b1; ackStb = 1'b1; ackLevel = 3'd4;
    @(negedge clk);
    ackStb = 1'b0; ackLevel = '0;
    chk("R11 ack data", ackData, 16'h013C);
    rdChk("R11 new edge kept", 2'd1, 16'h0110);
    doAck(3'd4, 1'b0, d, v);
    chk("R11 later ack", {15'd0, d}, 16'h0001);
  endtask

  task automatic tLevelZeroSoft();
    logic d; logic [15:0] v;
    wr(2'd0, 16'h0100);
    edge0();
    rdChk("R3 level zero no line", 2'd1, 16'h0100);
    doAck(3'd0, 1'b0, d, v);
    chk("R10 level zero ack", {15'd0, d}, 16'h0000);
    wr(2'd0, 16'h8106);
    @(negedge clk); softRst = 1'b1;
    @(negedge clk); softRst = 1'b0;
    rdChk("R8 soft keeps config", 2'd0, 16'h8100);
    rdChk("R8 soft clears status", 2'd1, 16'h0000);
    rdChk("R8 soft keeps id", 2'd2, 16'hBEEF);
    rdChk("R8 soft keeps options", 2'd3, 16'h5A0F);
    chk("R8 soft lines", {9'd0, irqN}, 16'h007F);
  endtask

  task automatic tHard();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    for (int a = 0; a < 4; a++) rdChk("R8 hard clears", 2'(a), 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tDrive();
    tSwAck();
    tNoResp();
    tNarrowSw();
    tLocal();
    tShared();
    tCollide();
    tLevelZeroSoft();
    tHard();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule